// File: doc/BRIEF.md
# Strobe-Handshake Fall-Through FIFO

This block is a first-in first-out buffer of 64 words of 5 bits. It sits between a producer and a consumer that do not share a clock-enable protocol. Instead, each side works with a level strobe and a ready flag. The producer raises its shift-in strobe while the input-ready flag is high, and the buffer takes the word on the data input. The consumer reads the word on the data output while the output-ready flag is high, then pulses its shift-out strobe to discard that word and move on to the next one.

Storage is a two-port register array with separate write and read pointers, so a producer and a consumer can be active in the same cycle. Both strobes are brought into the system clock domain with two-flop synchronizers. A word written into an empty buffer falls through to the output register on its own, with no read request. When the buffer runs empty, the last word read stays visible on the output. An output-enable input can float the data output.

Top module: `strobe_fifo`

## Requirements
- R1: The buffer holds up to 64 words of 5 bits, and returns them in the order they were written. A shift-in pulse and a shift-out pulse that overlap in time are both carried out: the head word is removed and the new word is appended behind the remaining words.
- R2: While shift-in is high and input-ready is high, the word on the data input is stored and input-ready goes low. Input-ready stays low for the rest of that strobe pulse.
- R3: After shift-in falls, the stored word counts as held. Input-ready then returns high if fewer than 64 words are held, and stays low if 64 are held.
- R4: With 64 words held, input-ready is low. If a shift-in pulse is still high when a shift-out pulse frees a location, its word is written once and input-ready goes low again. If a shift-in pulse ends while 64 words are held, it writes nothing.
- R5: When shift-out rises while output-ready is high, output-ready goes low. After shift-out falls, the next held word appears on the data output with output-ready high. If no word is left, output-ready stays low.
- R6: A word written into an empty buffer appears on the data output with output-ready high one cycle after it counts as held, without any shift-out pulse.
- R7: While the buffer is empty, the data output keeps the last word that was shown, and output-ready is low.
- R8: When master reset (active low) is asserted, output-ready is low, input-ready is high, the data output is all zero and every held word is discarded. The same state holds after reset is released.
- R9: When output enable is low, all five data output bits are high-impedance. Output enable does not change the held words or either ready flag.
- R10: A shift-out pulse that rises while output-ready is low is ignored and removes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, asynchronous assert, active low |
| din | input | 5 | Word to be shifted in |
| shift_in | input | 1 | Producer strobe, level, asynchronous to clk |
| shift_out | input | 1 | Consumer strobe, level, asynchronous to clk |
| out_en | input | 1 | High drives dout, low floats it |
| dout | output | 5 | Head word, or the last word shown |
| in_ready | output | 1 | Buffer can accept a word |
| out_ready | output | 1 | dout holds a valid unread word |

## Verification
The bound checker watches on every cycle for the invariants that hold no matter which strobe sequence drives them:
- the occupancy never goes past 64 and changes by at most one per cycle;
- input-ready is low at 64 words and output-ready is low at zero words;
- the output word changes only at the moment a new word is shown.

Other behaviours span several strobe pulses and can only be shown by the bench's scenarios:
- word order across overlapping pulses;
- the shift-in pulse held through a full buffer;
- a shift-out pulse that is ignored;
- the last word staying on the output;
- reset in the middle of a stream;
- floating the output.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Synchronized view of one strobe: level plus one-cycle edge pulses
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } strobe_t;
endpackage

// File: rtl/sfifo_rst_sync.sv
module sfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage   <= 1'b0;
      rst_n_o <= 1'b0;
    end else begin
      stage   <= 1'b1;
      rst_n_o <= stage;
    end
  end
endmodule

// File: rtl/sfifo_strobe_sync.sv
module sfifo_strobe_sync
  import sfifo_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin,
  output strobe_t st
);
  logic meta, lvl, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      lvl  <= 1'b0;
      prev <= 1'b0;
    end else begin
      meta <= pin;
      lvl  <= meta;
      prev <= lvl;
    end
  end

  always_comb begin
    st.lvl  = lvl;
    st.rise = lvl & ~prev;
    st.fall = ~lvl & prev;
  end
endmodule

// File: rtl/sfifo_ram.sv
module sfifo_ram #(
  parameter int W     = 5,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
#(
  parameter int W     = 5,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       si,
  input  strobe_t       so,
  input  logic [W-1:0]  rdata,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [W-1:0]  q,
  output logic          in_rdy,
  output logic          out_rdy,
  output logic [CW-1:0] occ
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

  logic          wr_pend, rd_pend;
  logic          wr_pend_n, rd_pend_n, in_rdy_n, out_rdy_n;
  logic [AW-1:0] wptr, rptr, wptr_n, rptr_n;
  logic [CW-1:0] occ_n;
  logic [W-1:0]  q_n;
  logic          start_wr, end_wr, start_rd, end_rd, load;

  // next-state logic
  always_comb begin
    start_wr = in_rdy & ~wr_pend & si.lvl;
    end_wr   = wr_pend & si.fall;
    start_rd = out_rdy & so.rise;
    end_rd   = rd_pend & so.fall;
    load     = ~out_rdy & ~rd_pend & (occ != '0);

    occ_n  = occ + CW'(end_wr) - CW'(end_rd);
    wptr_n = end_wr ? ((wptr == LAST_C) ? '0 : wptr + 1'b1) : wptr;
    rptr_n = end_rd ? ((rptr == LAST_C) ? '0 : rptr + 1'b1) : rptr;

    wr_pend_n = start_wr ? 1'b1 : (end_wr ? 1'b0 : wr_pend);
    rd_pend_n = start_rd ? 1'b1 : (end_rd ? 1'b0 : rd_pend);

    if (start_wr)                in_rdy_n = 1'b0;
    else if (wr_pend && !end_wr) in_rdy_n = 1'b0;
    else                         in_rdy_n = (occ_n < FULL_C);

    if (start_rd)  out_rdy_n = 1'b0;
    else if (load) out_rdy_n = 1'b1;
    else           out_rdy_n = out_rdy;

    q_n = load ? rdata : q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      occ     <= '0;
      wr_pend <= 1'b0;
      rd_pend <= 1'b0;
      in_rdy  <= 1'b1;
      out_rdy <= 1'b0;
      q       <= '0;
    end else begin
      wptr    <= wptr_n;
      rptr    <= rptr_n;
      occ     <= occ_n;
      wr_pend <= wr_pend_n;
      rd_pend <= rd_pend_n;
      in_rdy  <= in_rdy_n;
      out_rdy <= out_rdy_n;
      if (load) q <= q_n;
    end
  end

  assign we    = start_wr;
  assign waddr = wptr;
  assign raddr = rptr;
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         shift_in,
  input  logic         shift_out,
  input  logic         out_en,
  output logic [W-1:0] dout,
  output logic         in_ready,
  output logic         out_ready
);
  import sfifo_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          rst_n_s;
  strobe_t       strb [2];
  logic [1:0]    strb_pin;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [W-1:0]  rdata, q_word;
  logic [CW-1:0] occ;

  assign strb_pin = {shift_out, shift_in};

  sfifo_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_s));

  for (genvar g = 0; g < 2; g++) begin : g_sync
    sfifo_strobe_sync u_sync (
      .clk(clk), .rst_n(rst_n_s), .pin(strb_pin[g]), .st(strb[g])
    );
  end

  sfifo_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(rdata)
  );

  sfifo_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .si(strb[0]), .so(strb[1]),
    .rdata(rdata), .we(we), .waddr(waddr), .raddr(raddr),
    .q(q_word), .in_rdy(in_ready), .out_rdy(out_ready), .occ(occ)
  );

  assign dout = out_en ? q_word : {W{1'bz}};
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int W     = 5,
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_ready,
  input logic [CW-1:0] occ,
  input logic [W-1:0]  q
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_C);

  p_occ_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == $past(occ)) || (occ == $past(occ) + 1'b1) || (occ == $past(occ) - 1'b1));

  p_full_blocks_ir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL_C) |-> !in_ready);

  p_empty_no_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !out_ready);

  p_show_needs_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ready) |-> (occ != '0));

  p_q_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $rose(out_ready));
endmodule

bind strobe_fifo sfifo_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .in_ready(in_ready), .out_ready(out_ready),
  .occ(occ), .q(q_word)
);

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] din;
  logic       shift_in, shift_out, out_en;
  wire  [4:0] dout;
  logic       in_ready, out_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [4:0] mq[$];
  logic [4:0] last_word;

  always #4 clk = ~clk;

  strobe_fifo dut (
    .clk(clk), .rst_n(rst_n), .din(din), .shift_in(shift_in),
    .shift_out(shift_out), .out_en(out_en), .dout(dout),
    .in_ready(in_ready), .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_ir();
    return mq.size() < 64;
  endfunction

  task automatic chk_head(input string tag);
    if (mq.size() > 0) begin
      chk(out_ready === 1'b1, tag, {7'd0, out_ready}, 8'd1);
      chk(dout === mq[0], tag, {3'd0, dout}, {3'd0, mq[0]});
    end else begin
      chk(out_ready === 1'b0, tag, {7'd0, out_ready}, 8'd0);
      chk(dout === last_word, {tag, " R7"}, {3'd0, dout}, {3'd0, last_word});
    end
  endtask

  task automatic do_push(input logic [4:0] d);
    bit was_empty;
    was_empty = (mq.size() == 0);
    din = d; shift_in = 1'b1;
    settle(6);
    chk(in_ready === 1'b0, "R2 ir low in pulse", {7'd0, in_ready}, 8'd0);
    shift_in = 1'b0;
    settle(6);
    mq.push_back(d);
    chk(in_ready === exp_ir(), "R3 ir after pulse", {7'd0, in_ready}, {7'd0, exp_ir()});
    chk_head(was_empty ? "R6 fall-through" : "R1 head");
  endtask

  task automatic do_pop();
    chk_head("R5 head before pop");
    shift_out = 1'b1;
    settle(6);
    chk(out_ready === 1'b0, "R5 or low in pulse", {7'd0, out_ready}, 8'd0);
    shift_out = 1'b0;
    settle(6);
    last_word = mq.pop_front();
    chk_head("R5 next word");
  endtask

  task automatic do_both(input logic [4:0] d);
    din = d; shift_in = 1'b1; shift_out = 1'b1;
    settle(6);
    shift_in = 1'b0; shift_out = 1'b0;
    settle(6);
    last_word = mq.pop_front();
    mq.push_back(d);
    chk_head("R1 overlap");
    chk(in_ready === exp_ir(), "R1 ir overlap", {7'd0, in_ready}, {7'd0, exp_ir()});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    settle(3);
    chk(out_ready === 1'b0, "R8 or in reset", {7'd0, out_ready}, 8'd0);
    chk(in_ready === 1'b1, "R8 ir in reset", {7'd0, in_ready}, 8'd1);
    chk(dout === 5'd0, "R8 dout in reset", {3'd0, dout}, 8'd0);
    rst_n = 1'b1;
    settle(4);
    chk(out_ready === 1'b0 && in_ready === 1'b1 && dout === 5'd0,
        "R8 after release", {6'd0, in_ready, out_ready}, 8'd2);
    mq.delete();
    last_word = 5'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; din = '0; shift_in = 1'b0; shift_out = 1'b0; out_en = 1'b1;
    last_word = 5'd0;
    settle(2);
    do_reset();

    // R10: shift-out while nothing is shown
    shift_out = 1'b1; settle(6); shift_out = 1'b0; settle(6);
    chk(out_ready === 1'b0, "R10 empty pop", {7'd0, out_ready}, 8'd0);
    do_push(5'h15);
    chk(dout === 5'h15, "R10 word kept", {3'd0, dout}, 8'h15);

    // R9: output float, state untouched
    out_en = 1'b0; settle(2);
    chk(dout === 5'bzzzzz, "R9 float", {3'd0, dout}, 8'hff);
    chk(out_ready === 1'b1 && in_ready === 1'b1, "R9 flags kept",
        {6'd0, in_ready, out_ready}, 8'd3);
    out_en = 1'b1; settle(2);
    chk(dout === 5'h15, "R9 word kept", {3'd0, dout}, 8'h15);
    do_pop();

    // fill to 64
    for (int i = 0; i < 64; i++) do_push(5'(i * 7 + 3));
    chk(in_ready === 1'b0, "R3 full", {7'd0, in_ready}, 8'd0);

    // R4: pulse that ends while full writes nothing
    din = 5'h1f; shift_in = 1'b1; settle(6); shift_in = 1'b0; settle(6);
    chk(in_ready === 1'b0, "R4 dropped", {7'd0, in_ready}, 8'd0);

    // R4: held pulse taken once room appears
    din = 5'h0e; shift_in = 1'b1; settle(6);
    chk(in_ready === 1'b0, "R4 blocked", {7'd0, in_ready}, 8'd0);
    shift_out = 1'b1; settle(6); shift_out = 1'b0; settle(8);
    last_word = mq.pop_front();
    chk(in_ready === 1'b0, "R4 taken", {7'd0, in_ready}, 8'd0);
    shift_in = 1'b0; settle(6);
    mq.push_back(5'h0e);
    chk(in_ready === 1'b0, "R4 full again", {7'd0, in_ready}, 8'd0);
    chk_head("R4 head");

    // drain to empty
    while (mq.size() > 0) do_pop();
    chk(dout === last_word, "R7 last word kept", {3'd0, dout}, {3'd0, last_word});

    // random mix
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom % 3);
      if (r == 2 && mq.size() > 0 && mq.size() < 64) do_both(5'($urandom));
      else if ((r == 0 || mq.size() == 0) && mq.size() < 64) do_push(5'($urandom));
      else do_pop();
    end

    // reset in the middle of a stream
    do_push(5'h0a); do_push(5'h0b);
    do_reset();
    do_push(5'h11);
    chk(dout === 5'h11, "R8 restart", {3'd0, dout}, 8'h11);
    do_pop();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule